// File: doc/BRIEF.md
# System Clock Scaler

This block slows a master source clock for the logic behind it. It does not gate or switch clocks. It produces a clock-enable strobe, one source cycle wide, and downstream CPU and peripheral logic advance only on cycles where the strobe is high. Software controls it through one 8-bit configuration register. Bit 7 turns division on. Bits 6..0 hold a divide code `d`, and the division factor is 129 minus `d`, so factors run from 2 (code 127) up to 129 (code 0).

The code is locked while division is on. A new code takes effect only through the write that turns division on from the off state. While division is on, any write that keeps bit 7 set changes nothing. A write that clears bit 7 turns division off and ignores the code it carries. Software can turn division on and off at run time to change the clock rate. When division is off, the strobe stays high on every cycle, so the downstream logic runs at the full source rate.

Top module: `sysclk_scaler`

## Requirements
- R1: After reset the read-back value is 0x00, with bit 7 as the enable bit and bits 6..0 as the stored code.
- R2: While the enable bit is 0, including directly after reset, `tick_o` is high on every source cycle.
- R3: A write with bit 7 set, made while the enable bit is 0, sets the enable bit and stores bits 6..0 of that same write as the code. The read-back port then returns {1, code}.
- R4: While enabled with stored code d, `tick_o` is high for exactly one cycle in every 129 − d source cycles, so it is never high on two consecutive cycles.
- R5: After a write that enables division, the first strobe falls on the (129 − d)-th cycle after the clock edge that accepted the write. The counter restarts at that edge.
- R6: A write with bit 7 set, made while already enabled, leaves the enable bit and the stored code unchanged. It does not restart the strobe count.
- R7: A write with bit 7 clear turns division off and leaves the stored code unchanged, whatever code that write carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data: bit 7 is the enable bit, bits 6..0 are the code |
| rd_data_o | output | 8 | Read-back of the enable bit and the stored code |
| tick_o | output | 1 | Scaled clock-enable strobe |

## Verification
The main function is tested with codes at both ends of the range (0 and 127), with codes next to them (1 and 126), and with two codes in the middle. The two end codes show whether the factor arithmetic is off by one at its limits. The middle codes catch a factor that is inverted or taken from the wrong bits. For each code, the gap from the accepting write to the first strobe tells a counter restart apart from a free-running counter. The gap between later strobes measures the period itself. A write during a period that keeps bit 7 set, and a disabling write that carries a different code, show whether the lock and the code-discard rule hold.

// File: rtl/sysclk_scaler_pkg.sv
package sysclk_scaler_pkg;
  localparam int unsigned DEF_CODE_W = 7;

  typedef enum logic {
    MODE_PASS = 1'b0,
    MODE_DIV  = 1'b1
  } scale_mode_e;
endpackage

// File: rtl/sysclk_scaler_reg.sv
module sysclk_scaler_reg #(
  parameter int unsigned CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_on_i,
  input  logic [CODE_W-1:0] wr_code_i,
  output logic              en_o,
  output logic [CODE_W-1:0] code_o,
  output logic              accept_o
);
  logic              en_q;
  logic [CODE_W-1:0] code_q;

  // code only loads on the off-to-on write
  assign accept_o = wr_en_i & wr_on_i & ~en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      code_q <= '0;
    end else if (wr_en_i) begin
      if (accept_o) begin
        en_q   <= 1'b1;
        code_q <= wr_code_i;
      end else if (!wr_on_i) begin
        en_q <= 1'b0;
      end
    end
  end

  assign en_o   = en_q;
  assign code_o = code_q;

  AST_ACCEPT_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_on_i && !en_o) |=> (en_o && code_o == $past(wr_code_i))); // R3
  AST_LOCKED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_on_i && en_o) |=> (en_o && $stable(code_o))); // R6
  AST_OFF_KEEPS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_on_i) |=> (!en_o && $stable(code_o))); // R7
endmodule

// File: rtl/sysclk_scaler_factor.sv
module sysclk_scaler_factor #(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned FACT_W = CODE_W + 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [FACT_W-1:0] term_o
);
  // factor = 2^CODE_W + 1 - code; terminal count = factor - 1
  localparam logic [FACT_W-1:0] TOP_VAL = FACT_W'(2 ** CODE_W);

  assign term_o = TOP_VAL - FACT_W'(code_i);
endmodule

// File: rtl/sysclk_scaler_cnt.sv
module sysclk_scaler_cnt
  import sysclk_scaler_pkg::*;
#(
  parameter int unsigned FACT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic [FACT_W-1:0] term_i,
  output logic              tick_o
);
  scale_mode_e       mode;
  logic [FACT_W-1:0] cnt_q;
  logic              hit;

  assign mode = en_i ? MODE_DIV : MODE_PASS;
  assign hit  = (cnt_q == term_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (restart_i || mode == MODE_PASS) cnt_q <= '0;
    else if (hit)                         cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (mode == MODE_PASS) | hit;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= term_i)); // R4
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_o) |=> (!en_i || !tick_o)); // R4
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/sysclk_scaler.sv
module sysclk_scaler
  import sysclk_scaler_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  localparam int unsigned REG_W = CODE_W + 1,
  localparam int unsigned FACT_W = CODE_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             tick_o
);
  logic              en;
  logic              accept;
  logic [CODE_W-1:0] code;
  logic [FACT_W-1:0] term;

  sysclk_scaler_reg #(.CODE_W(CODE_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_on_i   (wr_data_i[REG_W-1]),
    .wr_code_i (wr_data_i[CODE_W-1:0]),
    .en_o      (en),
    .code_o    (code),
    .accept_o  (accept)
  );

  sysclk_scaler_factor #(.CODE_W(CODE_W), .FACT_W(FACT_W)) u_factor (
    .code_i (code),
    .term_o (term)
  );

  sysclk_scaler_cnt #(.FACT_W(FACT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .restart_i (accept),
    .term_i    (term),
    .tick_o    (tick_o)
  );

  assign rd_data_o = {en, code};

  AST_PASS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[REG_W-1] |-> tick_o); // R2
endmodule

// File: tb/sysclk_scaler_tb.sv
`timescale 1ns/1ps
module sysclk_scaler_tb;
  localparam time CLK_P = 20ns;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       tick_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sysclk_scaler u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .tick_o    (tick_o)
  );

  // {code, expected factor}
  localparam int NV = 6;
  localparam logic [14:0] VEC [NV] = '{
    {7'd0,   8'd129},
    {7'd127, 8'd2},
    {7'd126, 8'd3},
    {7'd1,   8'd128},
    {7'd64,  8'd65},
    {7'd100, 8'd29}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    @(negedge clk);
    wr_en_i   = 1'b0;
  endtask

  // call at the negedge right after the accepting edge
  task automatic first_gap(output int n);
    n = 1;
    while (!tick_o && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  // call at a negedge where tick_o is high
  task automatic tick_gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick_o && n < 400);
  endtask

  initial begin
    int n;
    int hi;
    repeat (3) @(negedge clk);
    check(rd_data_o == 8'h00, "R1 readback in reset", rd_data_o, 0);
    rst_ni = 1'b1;
    hi = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (tick_o) hi++;
    end
    check(rd_data_o == 8'h00, "R1 readback after reset", rd_data_o, 0);
    check(hi == 5, "R2 pass-through after reset", hi, 5);

    for (int i = 0; i < NV; i++) begin
      logic [6:0] c;
      int f;
      c = VEC[i][14:8];
      f = int'(VEC[i][7:0]);
      do_write({1'b0, c});
      do_write({1'b1, c});
      first_gap(n);
      check(rd_data_o == {1'b1, c}, "R3 enable captures code", rd_data_o, {1'b1, c});
      check(n == f, "R5 first strobe delay", n, f);
      tick_gap(n);
      check(n == f, "R4 strobe period", n, f);
    end

    // R6: locked write mid-period must not restart or reload
    do_write(8'h00);
    do_write(8'h80 | 8'd100);
    first_gap(n);
    @(negedge clk);
    n = 1;
    wr_en_i = 1'b1;
    wr_data_i = 8'hFF;
    @(negedge clk);
    n = 2;
    wr_en_i = 1'b0;
    while (!tick_o && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(n == 29, "R6 no restart on locked write", n, 29);
    check(rd_data_o == 8'hE4, "R6 code locked", rd_data_o, 8'hE4);
    tick_gap(n);
    check(n == 29, "R6 period unchanged", n, 29);

    // R7: disabling write carries a different code
    do_write(8'h05);
    check(rd_data_o == 8'h64, "R7 code kept on disable", rd_data_o, 8'h64);
    hi = 0;
    for (int k = 0; k < 4; k++) begin
      if (tick_o) hi++;
      @(negedge clk);
    end
    check(hi == 4, "R2 pass-through after disable", hi, 4);

    // R3 again: re-enable with a new code
    do_write(8'h85);
    first_gap(n);
    check(rd_data_o == 8'h85, "R3 new code on re-enable", rd_data_o, 8'h85);
    check(n == 124, "R5 first strobe after re-enable", n, 124);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule